// File: doc/BRIEF.md
# Vertically-and-Crosswise Unsigned Multiplier

This block multiplies two unsigned integers with no clock and no stored state. It is built on the column rule of the vertically-and-crosswise method. Column k of the result adds every bit product a_i·b_j with i+j = k, plus the carry that comes up from column k-1. The low bit of that column sum becomes result bit k, and the higher bits move on to the next column. A 2x2 cell applies this rule directly.

Every larger square is assembled from four half-width squares. These are the low·low, high·low, low·high and high·high sub-products. They are formed in parallel and placed at offsets 0, W/2, W/2 and W. Two carry-save rows merge them, and one carry-propagate adder resolves the result. The same construction repeats from 2x2 up to 32x32.

The operand width is a parameter from 2 to 32. An operand width that is not a power of two, such as a 24-bit significand, is zero-extended into the next power-of-two core, and only the meaningful low product bits are driven out. The block has no internal states or transitions: it is one combinational path from operands to product.

Top module: `vcm_mult`

## Requirements
- R1: For any pair of unsigned operands, `mul_p` equals the arithmetic product `mul_a * mul_b` as a 2*OPER_W-bit unsigned value.
- R2: Each 2x2 cell follows the column rule and never produces a value above 9. With both operands equal to 3 the product is 9, and with operands 2 and 3 it is 6.
- R3: If either operand is zero, every bit of the product is zero.
- R4: If one operand is 1, the product equals the other operand, zero-extended to 2*OPER_W bits.
- R5: All-ones times all-ones yields 2^(2N) - 2^(N+1) + 1. For N = 32 this is 0xFFFFFFFE00000001.
- R6: The product is purely combinational. It is valid in the same cycle the operands are applied, and no earlier operand pair affects it.
- R7: Every carry-save row preserves the sum of its three inputs, counting the carry bit that leaves the top of the row.
- R8: When OPER_W is not a power of two, the operands are zero-extended into the next power-of-two core. Core product bits above 2*OPER_W are then always zero. With OPER_W = 24, all-ones squared gives 0xFFFFFE000001.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | OPER_W | Unsigned multiplicand |
| mul_b | input | OPER_W | Unsigned multiplier |
| mul_p | output | 2*OPER_W | Unsigned product |

## Verification
The block holds no state. A fault in any sub-product, offset or carry-save row therefore shows on `mul_p` in the same cycle the operands are applied, and it stays there for as long as those operands are held. A wrong offset on a sub-product, or a lost carry, hits only certain bit columns. For that reason walking-one operands against an all-ones partner are used to reach each column of each level. All-ones squared is used because it drives the longest carry chains through every carry-save row. Zero-extension faults surface only on the narrow instance, so a 24-bit copy is compared alongside the 32-bit one.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
    localparam int MIN_W = 2;
    localparam int MAX_W = 32;

    // Smallest power of two that is at least w (never below MIN_W).
    function automatic int core_width(input int w);
        int r;
        r = MIN_W;
        while (r < w) r = r * 2;
        return r;
    endfunction
endpackage

// File: rtl/vcm_cell2.sv
module vcm_cell2 (
    input  logic [1:0] cell_a,
    input  logic [1:0] cell_b,
    output logic [3:0] cell_p
);
    logic       col0;
    logic [1:0] col1;
    logic [1:0] col2;

    always_comb begin
        col0   = cell_a[0] & cell_b[0];
        col1   = {1'b0, cell_a[1] & cell_b[0]} + {1'b0, cell_a[0] & cell_b[1]};
        col2   = {1'b0, col1[1]} + {1'b0, cell_a[1] & cell_b[1]};
        cell_p = {col2, col1[0], col0};
    end

    // 3 x 3 is the largest 2x2 product
    always_comb begin
        assert_cell_range_R2: assert (cell_p <= 4'd9)
            else $error("cell product %0d out of range", cell_p);
    end
endmodule

// File: rtl/vcm_csa.sv
module vcm_csa #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_x,
    input  logic [W-1:0] in_y,
    input  logic [W-1:0] in_z,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] carry_o
);
    logic [W-1:0] maj;

    always_comb begin
        sum_o   = in_x ^ in_y ^ in_z;
        maj     = (in_x & in_y) | (in_x & in_z) | (in_y & in_z);
        carry_o = {maj[W-2:0], 1'b0};
    end

    // sum plus weighted carries, including the one leaving the row
    always_comb begin
        assert_csa_conserve_R7: assert (
            ({2'b00, sum_o} + {2'b00, carry_o} + {1'b0, maj[W-1], {W{1'b0}}})
            == ({2'b00, in_x} + {2'b00, in_y} + {2'b00, in_z}))
            else $error("carry-save row lost weight");
    end
endmodule

// File: rtl/vcm_level.sv
module vcm_level #(
    parameter int W = 4
) (
    input  logic [W-1:0]   lvl_a,
    input  logic [W-1:0]   lvl_b,
    output logic [2*W-1:0] lvl_p
);
    localparam int H = W / 2;

    generate
        if (W == 2) begin : g_leaf
            vcm_cell2 u_cell (
                .cell_a(lvl_a),
                .cell_b(lvl_b),
                .cell_p(lvl_p)
            );
        end else begin : g_split
            logic [W-1:0]   sp_ll, sp_hl, sp_lh, sp_hh;
            logic [2*W-1:0] pp0, pp1, pp2, pp3;
            logic [2*W-1:0] s1, c1, s2, c2;

            vcm_level #(.W(H)) u_ll (.lvl_a(lvl_a[H-1:0]), .lvl_b(lvl_b[H-1:0]), .lvl_p(sp_ll));
            vcm_level #(.W(H)) u_hl (.lvl_a(lvl_a[W-1:H]), .lvl_b(lvl_b[H-1:0]), .lvl_p(sp_hl));
            vcm_level #(.W(H)) u_lh (.lvl_a(lvl_a[H-1:0]), .lvl_b(lvl_b[W-1:H]), .lvl_p(sp_lh));
            vcm_level #(.W(H)) u_hh (.lvl_a(lvl_a[W-1:H]), .lvl_b(lvl_b[W-1:H]), .lvl_p(sp_hh));

            always_comb begin
                pp0 = {{W{1'b0}}, sp_ll};
                pp1 = {{H{1'b0}}, sp_hl, {H{1'b0}}};
                pp2 = {{H{1'b0}}, sp_lh, {H{1'b0}}};
                pp3 = {sp_hh, {W{1'b0}}};
            end

            vcm_csa #(.W(2*W)) u_row0 (
                .in_x(pp0), .in_y(pp1), .in_z(pp2),
                .sum_o(s1), .carry_o(c1)
            );
            vcm_csa #(.W(2*W)) u_row1 (
                .in_x(s1), .in_y(c1), .in_z(pp3),
                .sum_o(s2), .carry_o(c2)
            );

            assign lvl_p = s2 + c2;
        end
    endgenerate

    always_comb begin
        assert_zero_operand_R3: assert (!((lvl_a == '0) || (lvl_b == '0)) || (lvl_p == '0))
            else $error("zero operand gave nonzero product");
        assert_unit_operand_R4: assert (!(lvl_a == W'(1)) || (lvl_p == {{W{1'b0}}, lvl_b}))
            else $error("unit operand did not pass the other through");
    end
endmodule

// File: rtl/vcm_mult.sv
module vcm_mult #(
    parameter int OPER_W = 32
) (
    input  logic [OPER_W-1:0]   mul_a,
    input  logic [OPER_W-1:0]   mul_b,
    output logic [2*OPER_W-1:0] mul_p
);
    localparam int CORE_W = vcm_pkg::core_width(OPER_W);

    logic [CORE_W-1:0]   ext_a, ext_b;
    logic [2*CORE_W-1:0] core_p;

    assign ext_a = CORE_W'(mul_a);
    assign ext_b = CORE_W'(mul_b);

    vcm_level #(.W(CORE_W)) u_core (
        .lvl_a(ext_a),
        .lvl_b(ext_b),
        .lvl_p(core_p)
    );

    assign mul_p = core_p[2*OPER_W-1:0];

    generate
        if (CORE_W > OPER_W) begin : g_pad
            always_comb begin
                assert_pad_zero_R8: assert (core_p[2*CORE_W-1:2*OPER_W] == '0)
                    else $error("padded core produced high product bits");
            end
        end
    endgenerate
endmodule

// File: tb/test_vcm_mult.sv
module test_vcm_mult;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [31:0] op_a = '0, op_b = '0;
    logic [63:0] prod32;
    logic [47:0] prod24;

    vcm_mult #(.OPER_W(32)) i_vcm_mult (.mul_a(op_a), .mul_b(op_b), .mul_p(prod32));
    vcm_mult #(.OPER_W(24)) i_vcm_mult_w24 (.mul_a(op_a[23:0]), .mul_b(op_b[23:0]), .mul_p(prod24));

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] exp32;
        logic [47:0] exp24;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic push(input logic [31:0] a, input logic [31:0] b, input string tag);
        item_t it;
        logic [63:0] w24;
        @(posedge clk);
        #1;
        op_a = a;
        op_b = b;
        it.a = a;
        it.b = b;
        it.tag = tag;
        it.exp32 = {32'b0, a} * {32'b0, b};
        w24 = {40'b0, a[23:0]} * {40'b0, b[23:0]};
        it.exp24 = w24[47:0];
        sb_q.push_back(it);
    endtask

    // monitor: compare half a cycle after each drive
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (prod32 !== it.exp32) begin
                    errors++;
                    $display("FAIL %s (32-bit): a=%h b=%h got %h expected %h",
                             it.tag, it.a, it.b, prod32, it.exp32);
                end
                checks++;
                if (prod24 !== it.exp24) begin
                    errors++;
                    $display("FAIL %s (24-bit): a=%h b=%h got %h expected %h",
                             it.tag, it.a[23:0], it.b[23:0], prod24, it.exp24);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state operands: zero in, zero out (R3)
        push(32'h0, 32'h0, "R3");
        push(32'h0, 32'hFFFF_FFFF, "R3");
        push(32'hDEAD_BEEF, 32'h0, "R3");
        // unit operand (R4)
        push(32'h1, 32'h89AB_CDEF, "R4");
        push(32'h7654_3210, 32'h1, "R4");
        // 2x2 cell column rule (R2)
        push(32'h3, 32'h3, "R2");
        push(32'h2, 32'h3, "R2");
        push(32'h1, 32'h1, "R2");
        // longest carries (R5) and padded core (R8)
        push(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R5");
        push(32'h00FF_FFFF, 32'h00FF_FFFF, "R8");
        push(32'hFF80_0001, 32'h0180_0003, "R8");
        // back-to-back pairs, no history (R6)
        push(32'hAAAA_AAAA, 32'h5555_5555, "R6");
        push(32'h5555_5555, 32'hAAAA_AAAA, "R6");
        push(32'h0, 32'h1234_5678, "R6");
        // every column reached by walking ones (R1)
        for (int i = 0; i < 32; i++) push(32'h1 << i, 32'hFFFF_FFFF, "R1");
        for (int i = 0; i < 32; i++) push(32'hFFFF_FFFF, 32'h1 << i, "R1");
        // random operands (R1)
        for (int i = 0; i < 400; i++) push($urandom, $urandom, "R1");
        wait (sb_q.size() == 0);
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule